// File: doc/BRIEF.md
# Sliding-Window Sign-Controlled Correlation Accumulator

This block keeps a matrix of signed correlation sums with ROWS rows by COLS columns. Each row belongs to one antipodal training bit and each column to one received chip position. Over a sliding window of bit periods, it adds the contribution of the bit period that enters the window and removes the contribution of the period that leaves it. Because every bit is +1 or -1, each product of a bit and a sample reduces to adding or subtracting the sample, so no multiplier is needed.

Samples arrive one pair per clock with a valid strobe. Each pair holds the entering chip sample and the leaving chip sample for the current column. The two bit vectors for a period are taken with the first sample of that period. After COLS accepted samples, every entry has been updated and a one-cycle done pulse is raised. A combinational read port returns any entry. A synchronous clear empties the matrix and restarts the period.

Top module: `signcorr_accum`

## Requirements
- R1: After reset, every entry reads 0, `done` is low and the next accepted sample goes to column 0.
- R2: Each cycle with `in_valid` high and `clr` low updates column c of every row. Here c is the number of samples accepted earlier in the current period (0 to COLS-1). Cycles with `in_valid` low change no entry and do not advance the column.
- R3: Entering term: for row r, `new_bits[r]`=1 adds `new_samp` and `new_bits[r]`=0 subtracts it. `new_samp` is 8-bit two's complement.
- R4: Leaving term: for row r, `old_bits[r]`=1 subtracts `old_samp` and `old_bits[r]`=0 adds it. `old_samp` is 8-bit two's complement. When a period's own data is later fed back as leaving data, that period's contribution is removed.
- R5: Both bit vectors are captured on the first accepted sample of a period, at column 0. Their values on the remaining samples of the period have no effect.
- R6: Per update, the entering and leaving terms are summed first. That signed sum is added to the 16-bit entry once, and the result is clamped to the range -32768 to 32767.
- R7: `done` is high for exactly one cycle. It rises in the cycle after the clock edge that accepts the COLS-th sample of a period, and at that point all entries already hold their updated values.
- R8: `clr` is synchronous and has priority over `in_valid`. At the next edge it sets all entries to 0 and the column to 0, it drops `done`, and any sample offered in the same cycle is discarded.
- R9: `rd_data` combinationally shows the entry addressed by `rd_row` and `rd_col` as a 16-bit signed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous matrix clear and period restart |
| in_valid | input | 1 | Sample pair valid |
| new_bits | input | ROWS | Bits of the entering period, 1 means +1 |
| old_bits | input | ROWS | Bits of the leaving period, 1 means +1 |
| new_samp | input | 8 | Entering chip sample, signed |
| old_samp | input | 8 | Leaving chip sample, signed |
| rd_row | input | log2(ROWS) | Read row index |
| rd_col | input | log2(COLS) | Read column index |
| rd_data | output | 16 | Addressed entry, signed |
| done | output | 1 | One-cycle pulse when a period completes |

## Verification
An accepted sample changes its column at the edge where it is offered. The bench therefore drives each pair on a falling edge and reads `done` one time unit after the following rising edge, where the pulse must be high only for the COLS-th sample. The read port adds no delay, so entries are read after a short settle time once `in_valid` is low. Idle cycles leave the matrix unchanged, so every entry can be compared against a model that steps once per accepted sample. A clear, or a clear offered together with a sample, is checked in the cycle right after its edge.

// File: rtl/sca_pkg.sv
`timescale 1ns/1ps
package sca_pkg;
    parameter int unsigned SAMP_W_DEF = 8;
    parameter int unsigned ACC_W_DEF  = 16;

    typedef enum logic {
        SGN_MINUS = 1'b0,
        SGN_PLUS  = 1'b1
    } sgn_e;
endpackage

// File: rtl/sca_lane.sv
`timescale 1ns/1ps
module sca_lane #(
    parameter int unsigned SAMP_W = sca_pkg::SAMP_W_DEF,
    parameter int unsigned ACC_W  = sca_pkg::ACC_W_DEF
) (
    input  logic signed [ACC_W-1:0]  acc_in,
    input  logic                     new_bit,
    input  logic                     old_bit,
    input  logic signed [SAMP_W-1:0] new_samp,
    input  logic signed [SAMP_W-1:0] old_samp,
    output logic signed [ACC_W-1:0]  acc_out
);
    localparam int unsigned DW = SAMP_W + 2;
    localparam int unsigned SW = ACC_W + 2;
    localparam logic signed [SW-1:0] MAXV = {3'b000, {(ACC_W-1){1'b1}}};
    localparam logic signed [SW-1:0] MINV = {3'b111, {(ACC_W-1){1'b0}}};

    logic signed [DW-1:0] n_ext, o_ext, n_term, o_term, delta;
    logic signed [SW-1:0] sum;

    always_comb begin
        n_ext  = DW'(new_samp);
        o_ext  = DW'(old_samp);
        // entering bit: +1 adds, -1 subtracts
        n_term = (new_bit == sca_pkg::SGN_PLUS) ? n_ext : -n_ext;
        // leaving bit: inverse operation
        o_term = (old_bit == sca_pkg::SGN_PLUS) ? -o_ext : o_ext;
        delta  = n_term + o_term;
        sum    = SW'(acc_in) + SW'(delta);
        if (sum > MAXV) begin
            acc_out = MAXV[ACC_W-1:0];
        end else if (sum < MINV) begin
            acc_out = MINV[ACC_W-1:0];
        end else begin
            acc_out = sum[ACC_W-1:0];
        end
    end

    always_comb begin
        AST_NO_WRAP_UP: assert (delta[DW-1] || (acc_out >= acc_in)); // R6
        AST_NO_WRAP_DN: assert (!delta[DW-1] || (acc_out <= acc_in)); // R6
    end
endmodule

// File: rtl/sca_seq.sv
`timescale 1ns/1ps
module sca_seq #(
    parameter int unsigned ROWS = 8,
    parameter int unsigned COLS = 8,
    localparam int unsigned CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            in_valid,
    input  logic [ROWS-1:0] new_bits,
    input  logic [ROWS-1:0] old_bits,
    output logic [CW-1:0]   col,
    output logic            upd,
    output logic [ROWS-1:0] eff_new,
    output logic [ROWS-1:0] eff_old,
    output logic            done
);
    localparam logic [CW-1:0] LAST = CW'(COLS - 1);

    typedef struct packed {
        logic [CW-1:0]   col;
        logic            done;
        logic [ROWS-1:0] nb;
        logic [ROWS-1:0] ob;
    } st_t;

    st_t  st_d, st_q;
    logic first;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        first     = (st_q.col == '0);
        eff_new   = first ? new_bits : st_q.nb;
        eff_old   = first ? old_bits : st_q.ob;
        upd       = in_valid && !clr;
        if (clr) begin
            st_d.col = '0;
        end else if (in_valid) begin
            if (first) begin
                st_d.nb = new_bits;
                st_d.ob = old_bits;
            end
            if (st_q.col == LAST) begin
                st_d.col  = '0;
                st_d.done = 1'b1;
            end else begin
                st_d.col = st_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col  = st_q.col;
    assign done = st_q.done;

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clr && st_q.col == LAST) |=> st_q.done); // R7
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> $past(in_valid && !clr)); // R7
    AST_COL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !clr) |=> $stable(st_q.col)); // R2
    AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.col == '0 && !st_q.done)); // R8
endmodule

// File: rtl/signcorr_accum.sv
`timescale 1ns/1ps
module signcorr_accum #(
    parameter int unsigned ROWS   = 8,
    parameter int unsigned COLS   = 8,
    parameter int unsigned SAMP_W = sca_pkg::SAMP_W_DEF,
    parameter int unsigned ACC_W  = sca_pkg::ACC_W_DEF,
    localparam int unsigned RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int unsigned CW    = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     in_valid,
    input  logic [ROWS-1:0]          new_bits,
    input  logic [ROWS-1:0]          old_bits,
    input  logic signed [SAMP_W-1:0] new_samp,
    input  logic signed [SAMP_W-1:0] old_samp,
    input  logic [RW-1:0]            rd_row,
    input  logic [CW-1:0]            rd_col,
    output logic signed [ACC_W-1:0]  rd_data,
    output logic                     done
);
    logic [CW-1:0]   col;
    logic            upd;
    logic [ROWS-1:0] eff_new, eff_old;

    logic signed [ACC_W-1:0] mat_d  [ROWS][COLS];
    logic signed [ACC_W-1:0] mat_q  [ROWS][COLS];
    logic signed [ACC_W-1:0] lane_in  [ROWS];
    logic signed [ACC_W-1:0] lane_out [ROWS];

    sca_seq #(.ROWS(ROWS), .COLS(COLS)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .in_valid (in_valid),
        .new_bits (new_bits),
        .old_bits (old_bits),
        .col      (col),
        .upd      (upd),
        .eff_new  (eff_new),
        .eff_old  (eff_old),
        .done     (done)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign lane_in[r] = mat_q[r][col];
        sca_lane #(.SAMP_W(SAMP_W), .ACC_W(ACC_W)) lane_i (
            .acc_in   (lane_in[r]),
            .new_bit  (eff_new[r]),
            .old_bit  (eff_old[r]),
            .new_samp (new_samp),
            .old_samp (old_samp),
            .acc_out  (lane_out[r])
        );
    end

    always_comb begin
        mat_d = mat_q;
        for (int r = 0; r < ROWS; r++) begin
            if (clr) begin
                for (int c = 0; c < COLS; c++) begin
                    mat_d[r][c] = '0;
                end
            end else if (upd) begin
                mat_d[r][col] = lane_out[r];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    mat_q[r][c] <= '0;
                end
            end
        end else begin
            mat_q <= mat_d;
        end
    end

    assign rd_data = mat_q[rd_row][rd_col];

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rd_data == '0)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !clr) |=> (($past(rd_row) != rd_row) ||
                                 ($past(rd_col) != rd_col) ||
                                 $stable(rd_data))); // R2
endmodule

// File: tb/signcorr_accum_tb_top.sv
`timescale 1ns/1ps
module signcorr_accum_tb_top;
    localparam int ROWS = 8;
    localparam int COLS = 8;
    localparam int RW   = $clog2(ROWS);
    localparam int CW   = $clog2(COLS);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                clr = 1'b0;
    logic                in_valid = 1'b0;
    logic [ROWS-1:0]     new_bits = '0;
    logic [ROWS-1:0]     old_bits = '0;
    logic signed [7:0]   new_samp = '0;
    logic signed [7:0]   old_samp = '0;
    logic [RW-1:0]       rd_row = '0;
    logic [CW-1:0]       rd_col = '0;
    logic signed [15:0]  rd_data;
    logic                done;

    int n_cmp = 0;
    int n_bad = 0;
    bit summary_done = 0;

    int model [ROWS][COLS];
    int mcol = 0;
    logic [ROWS-1:0] mnb = '0, mob = '0;

    always #2.5 clk = ~clk;

    signcorr_accum #(.ROWS(ROWS), .COLS(COLS)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .new_bits(new_bits), .old_bits(old_bits),
        .new_samp(new_samp), .old_samp(old_samp),
        .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data), .done(done)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int smp(input int seed, input int j);
        if (seed == 0) return 0;
        if (seed == 1) return 127;
        if (seed == 2) return -128;
        return ((seed * 37 + j * 53 + 11) % 256) - 128;
    endfunction

    task automatic model_clear();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                model[r][c] = 0;
        mcol = 0;
    endtask

    // one accepted sample pair; checks done timing (R7)
    task automatic feed(input logic [ROWS-1:0] nb, input logic [ROWS-1:0] ob,
                        input int ns, input int os, input int gap);
        bit exp_done;
        repeat (gap) @(posedge clk);
        @(negedge clk);
        in_valid = 1'b1; new_bits = nb; old_bits = ob;
        new_samp = 8'(ns); old_samp = 8'(os);
        @(posedge clk); #1;
        in_valid = 1'b0;
        if (mcol == 0) begin mnb = nb; mob = ob; end
        for (int r = 0; r < ROWS; r++) begin
            int d;
            d = (mnb[r] ? ns : -ns) + (mob[r] ? -os : os);
            model[r][mcol] = sat16(model[r][mcol] + d);
        end
        exp_done = (mcol == COLS - 1);
        mcol = (mcol + 1) % COLS;
        chk("R7 done pulse", int'(done), int'(exp_done));
    endtask

    task automatic period(input logic [ROWS-1:0] nb, input logic [ROWS-1:0] ob,
                          input int sn, input int so, input int gap,
                          input logic [ROWS-1:0] mid_nb, input logic [ROWS-1:0] mid_ob);
        for (int j = 0; j < COLS; j++) begin
            if (j == 0) feed(nb, ob, smp(sn, j), smp(so, j), gap);
            else        feed(mid_nb, mid_ob, smp(sn, j), smp(so, j), gap);
        end
    endtask

    task automatic check_all(input string tag);
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                rd_row = RW'(r); rd_col = CW'(c);
                #0.5;
                chk($sformatf("%s R9 entry[%0d][%0d]", tag, r, c), int'(rd_data), model[r][c]);
            end
        end
    endtask

    task automatic t_reset();
        model_clear();
        check_all("R1 reset");
        chk("R1 done after reset", int'(done), 0);
    endtask

    task automatic t_add();
        period(8'b1010_0110, 8'h00, 5, 0, 0, 8'b1010_0110, 8'h00);
        check_all("R3 add/sub by new bit");
        feed(8'hFF, 8'h00, -128, 0, 0);
        feed(8'hFF, 8'h00, 127, 0, 0);
        check_all("R3 extremes");
        for (int j = 2; j < COLS; j++) feed(8'hFF, 8'h00, 0, 0, 0);
    endtask

    task automatic t_slide();
        period(8'b0101_1100, 8'b1010_0110, 9, 5, 0, 8'b0101_1100, 8'b1010_0110);
        check_all("R4 leaving term removed");
        period(8'b0011_0011, 8'b0101_1100, 0, 9, 0, 8'b0011_0011, 8'b0101_1100);
        check_all("R4 second slide");
    endtask

    task automatic t_gap();
        feed(8'hC3, 8'h3C, 40, -20, 0);
        feed(8'hC3, 8'h3C, -7, 33, 0);
        repeat (6) @(posedge clk);
        #1;
        check_all("R2 idle no change");
        for (int j = 2; j < COLS; j++) feed(8'hC3, 8'h3C, smp(17, j), smp(23, j), 3);
        check_all("R2 column order with gaps");
    endtask

    task automatic t_bits_hold();
        period(8'b1111_0000, 8'b0000_1111, 29, 31, 0, 8'b0000_1111, 8'b1111_0000);
        check_all("R5 bits held over period");
    endtask

    task automatic t_sat();
        for (int p = 0; p < 132; p++)
            period(8'b1111_0000, 8'b1111_0000, 1, 2, 0, 8'b1111_0000, 8'b1111_0000);
        check_all("R6 clamp");
        rd_row = RW'(7); rd_col = CW'(0); #0.5;
        chk("R6 upper limit", int'(rd_data), 32767);
        rd_row = RW'(0); rd_col = CW'(3); #0.5;
        chk("R6 lower limit", int'(rd_data), -32768);
        period(8'b0000_1111, 8'b0000_1111, 1, 2, 0, 8'b0000_1111, 8'b0000_1111);
        check_all("R6 leave saturation");
        rd_row = RW'(7); rd_col = CW'(0); #0.5;
        chk("R6 step down from limit", int'(rd_data), 32767 - 255);
    endtask

    task automatic t_clr();
        feed(8'hAA, 8'h55, 50, 60, 0);
        feed(8'hAA, 8'h55, 51, 61, 0);
        feed(8'hAA, 8'h55, 52, 62, 0);
        @(negedge clk);
        clr = 1'b1; in_valid = 1'b1; new_bits = 8'hFF; new_samp = 8'sd100;
        @(posedge clk); #1;
        clr = 1'b0; in_valid = 1'b0;
        model_clear();
        chk("R8 done low after clear", int'(done), 0);
        check_all("R8 clear with valid");
        period(8'h96, 8'h00, 13, 0, 0, 8'h96, 8'h00);
        check_all("R8 restart at column 0");
    endtask

    initial begin
        #(5.0 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_add();
        t_slide();
        t_gap();
        t_bits_hold();
        t_sat();
        t_clr();
        summary();
        $finish;
    end
endmodule